// File: doc/BRIEF.md
# Parallel EPROM Bank Read Controller

This block sits on the host side of a bank of byte-wide EPROMs that share one 8-bit data bus. Each device stores 64K bytes. The host presents a byte address together with a valid strobe. The low 16 address bits go to every device. The bits above them pick exactly one device, whose active-low chip enable is pulled low. A single active-low output enable is wired to all devices in common. Because of this, the decoded chip enable is the only thing that decides which device drives the bus.

Three cycle counts, given as parameters, replace the analog timing:
- `ACC_CYC`: address and chip enable to valid data.
- `OE_CYC`: output enable to valid data.
- `FLOAT_CYC`: bus release after deselect.

The controller holds output enable back for `ACC_CYC - OE_CYC` cycles (clamped at zero). This way the whole access takes exactly max(`ACC_CYC`, `OE_CYC`) enabled cycles. On the last enabled cycle it registers the bus and raises a one-cycle data-valid pulse. It then deselects every device and waits out the float time before it accepts the next request through a ready/valid handshake.

The sequencer has four states:
- `ST_IDLE`: ready, nothing selected. On an accepted request, goes to `ST_SETUP`, or straight to `ST_ACCESS` when the output-enable lead is zero.
- `ST_SETUP`: chip enable low, output enable high. Goes to `ST_ACCESS` when the lead expires.
- `ST_ACCESS`: both enables low. When its count expires, the data is captured and the state goes to `ST_FLOAT`.
- `ST_FLOAT`: everything deselected while the bus floats. Returns to `ST_IDLE` when the float count expires.

Top module: `eprom_bank_reader`

## Requirements
- R1: While a device is selected, `mem_addr` equals request address bits [15:0]. The selected device is `req_addr[ADDR_W-1:16]`, and device k is selected by driving `mem_ce_n[k]` low.
- R2: At most one `mem_ce_n` bit is low at any time. After reset, all `mem_ce_n` bits and `mem_oe_n` are high, `req_ready` is 1 and `rd_valid` is 0.
- R3: `mem_oe_n` is low only while a device is selected. It first goes low in enabled cycle max(`ACC_CYC`-`OE_CYC`,0)+1 of an access, where enabled cycle 1 is the first cycle with the chip enable low.
- R4: During an access, `mem_addr` and `mem_ce_n` stay unchanged from the first enabled cycle until the data is captured.
- R5: The bus is sampled at the clock edge that ends enabled cycle T = max(`ACC_CYC`,`OE_CYC`). `rd_valid` is high in the cycle after that edge, with the sampled byte on `rd_data`, and both enables are already high in that cycle.
- R6: `rd_valid` is high for exactly one cycle per accepted request.
- R7: After deselect, no chip enable goes low for at least `FLOAT_CYC` cycles. `req_ready` is low from acceptance until the float interval has ended, and a request held during that time is neither accepted nor answered twice.
- R8: With a request held continuously, successive acceptances are exactly T+`FLOAT_CYC`+1 cycles apart. The first read's `rd_valid` appears T+1 cycles after its acceptance edge.
- R9: When `ACC_CYC` <= `OE_CYC`, chip enable and output enable go low in the same cycle, and T equals `OE_CYC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W (16+clog2(N_DEV)) | Byte address; upper bits pick the device |
| req_ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | DW | Captured byte |
| mem_addr | output | DEV_AW | Address shared by all devices |
| mem_ce_n | output | N_DEV | Active-low chip enable, one per device |
| mem_oe_n | output | 1 | Active-low output enable common to all devices |
| mem_dq | input | DW | Shared data bus from the devices |

## Verification
The hardest condition to reach is a request waiting while the previous access is still floating the bus. With a properly behaved host, the next request would simply arrive later and the gap would never be measured.

The driver therefore leaves `req_valid` high with a new address immediately after each acceptance. This forces the handshake to hold it off through the whole float interval, and the acceptance spacing is then measured exactly.

The bench's device model returns a junk byte unless both the chip-enable age and the output-enable age have reached their counts. Any capture that comes too early therefore shows up as a data mismatch. A second instance with the output-enable time longer than the address time exercises the variant with no setup phase.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_FLOAT  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
    parameter int N_DEV = 4,
    parameter int SEL_W = 2
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [N_DEV-1:0] ce_n
);

    for (genvar k = 0; k < N_DEV; k++) begin : g_dev
        assign ce_n[k] = !(en && (sel == SEL_W'(k)));
    end

endmodule

// File: rtl/eprom_rd_fsm.sv
module eprom_rd_fsm
    import eprom_rd_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int OE_CYC    = 2,
    parameter int FLOAT_CYC = 2,
    parameter int CW        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic ce_active,
    output logic oe_active,
    output logic capture
);

    rd_state_e     state_q, state_d;
    rd_state_e     first_st;
    logic [CW-1:0] first_ld;
    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;

    // Entry path out of idle depends on whether output enable needs a lead
    if (SETUP_CYC > 0) begin : g_lead
        assign first_st = ST_SETUP;
        assign first_ld = CW'(SETUP_CYC - 1);
    end else begin : g_nolead
        assign first_st = ST_ACCESS;
        assign first_ld = CW'(OE_CYC - 1);
    end

    eprom_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d  = first_st;
                    load     = 1'b1;
                    load_val = first_ld;
                end
            end
            ST_SETUP: begin
                if (expired) begin
                    state_d  = ST_ACCESS;
                    load     = 1'b1;
                    load_val = CW'(OE_CYC - 1);
                end
            end
            ST_ACCESS: begin
                if (expired) begin
                    state_d  = ST_FLOAT;
                    load     = 1'b1;
                    load_val = CW'(FLOAT_CYC - 1);
                end
            end
            ST_FLOAT: begin
                if (expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready && req_valid;
        ce_active = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
        oe_active = (state_q == ST_ACCESS);
        capture   = (state_q == ST_ACCESS) && expired;
    end

endmodule

// File: rtl/eprom_bank_reader.sv
module eprom_bank_reader #(
    parameter int N_DEV     = 4,
    parameter int DEV_AW    = 16,
    parameter int DW        = 8,
    parameter int ACC_CYC   = 5,
    parameter int OE_CYC    = 2,
    parameter int FLOAT_CYC = 2,
    localparam int SEL_W    = $clog2(N_DEV),
    localparam int ADDR_W   = DEV_AW + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic [DEV_AW-1:0] mem_addr,
    output logic [N_DEV-1:0]  mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DW-1:0]     mem_dq
);

    localparam int SETUP_CYC = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 0;
    localparam int MAX_A     = (SETUP_CYC > OE_CYC) ? SETUP_CYC : OE_CYC;
    localparam int MAX_WAIT  = (MAX_A > FLOAT_CYC) ? MAX_A : FLOAT_CYC;
    localparam int CW        = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              ce_active;
    logic              oe_active;
    logic              capture;

    eprom_rd_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .OE_CYC    (OE_CYC),
        .FLOAT_CYC (FLOAT_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .ce_active (ce_active),
        .oe_active (oe_active),
        .capture   (capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end
    end

    eprom_ce_decode #(
        .N_DEV (N_DEV),
        .SEL_W (SEL_W)
    ) u_dec (
        .en   (ce_active),
        .sel  (addr_q[ADDR_W-1:DEV_AW]),
        .ce_n (mem_ce_n)
    );

    assign mem_addr = addr_q[DEV_AW-1:0];
    assign mem_oe_n = !oe_active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= mem_dq;
            end
        end
    end

endmodule

// File: rtl/eprom_bank_reader_chk.sv
module eprom_bank_reader_chk #(
    parameter int N_DEV     = 4,
    parameter int DEV_AW    = 16,
    parameter int FLOAT_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_DEV-1:0]  mem_ce_n,
    input logic              mem_oe_n,
    input logic [DEV_AW-1:0] mem_addr,
    input logic              rd_valid,
    input logic              req_ready
);

    localparam int GW = $clog2(FLOAT_CYC + 2);

    logic [GW-1:0] gap_cnt;
    logic          seen_sel;
    logic          all_off;

    assign all_off = &mem_ce_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            seen_sel <= 1'b0;
        end else if (all_off) begin
            if (gap_cnt != GW'(FLOAT_CYC)) gap_cnt <= gap_cnt + 1'b1;
        end else begin
            gap_cnt  <= '0;
            seen_sel <= 1'b1;
        end
    end

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n)); // R2

    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !all_off); // R3

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_off && !$past(all_off)) |-> ($stable(mem_addr) && $stable(mem_ce_n))); // R4

    AST_VALID_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (all_off && mem_oe_n)); // R5

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_off && seen_sel && gap_cnt != '0) |-> (gap_cnt >= GW'(FLOAT_CYC))); // R7

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (all_off && mem_oe_n)); // R7

endmodule

bind eprom_bank_reader eprom_bank_reader_chk #(
    .N_DEV     (N_DEV),
    .DEV_AW    (DEV_AW),
    .FLOAT_CYC (FLOAT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .rd_valid  (rd_valid),
    .req_ready (req_ready)
);

// File: tb/eprom_bank_reader_tb.sv
module eprom_bank_reader_tb;

    localparam int N_DEV = 4;
    localparam int DEV_AW = 16;
    localparam int ACC = 5;
    localparam int OEC = 2;
    localparam int FL = 2;
    localparam int AW = DEV_AW + 2;
    localparam int S = (ACC > OEC) ? ACC - OEC : 0;
    localparam int T = S + OEC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic              req_ready;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic [DEV_AW-1:0] mem_addr;
    logic [N_DEV-1:0]  mem_ce_n;
    logic              mem_oe_n;
    logic [7:0]        mem_dq = 8'hEE;

    eprom_bank_reader #(
        .N_DEV(N_DEV), .DEV_AW(DEV_AW), .DW(8),
        .ACC_CYC(ACC), .OE_CYC(OEC), .FLOAT_CYC(FL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    // Variant with no output-enable lead: ACC 2, OE 3, float 1
    logic              f_valid = 1'b0;
    logic [16:0]       f_addr = '0;
    logic              f_ready;
    logic              f_rd_valid;
    logic [7:0]        f_rd_data;
    logic [DEV_AW-1:0] f_mem_addr;
    logic [1:0]        f_ce_n;
    logic              f_oe_n;
    logic [7:0]        f_dq;

    assign f_dq = f_mem_addr[7:0] ^ 8'h5A;

    eprom_bank_reader #(
        .N_DEV(2), .DEV_AW(DEV_AW), .DW(8),
        .ACC_CYC(2), .OE_CYC(3), .FLOAT_CYC(1)
    ) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .req_valid(f_valid), .req_addr(f_addr),
        .req_ready(f_ready), .rd_valid(f_rd_valid), .rd_data(f_rd_data),
        .mem_addr(f_mem_addr), .mem_ce_n(f_ce_n), .mem_oe_n(f_oe_n), .mem_dq(f_dq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_val(input int dev, input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'(dev * 37 + 5);
    endfunction

    typedef struct {
        logic [7:0] data;
        int         when;
    } exp_t;
    exp_t exp_q[$];

    int              cur_dev = 0;
    logic [15:0]     cur_low = '0;

    // Device bank model: valid data only once both enable ages reach their counts
    int  ce_age = 0;
    int  oe_age = 0;
    int  high_run = 0;
    bit  seen_sel = 0;
    always @(negedge clk) begin
        int idx;
        idx = -1;
        for (int k = 0; k < N_DEV; k++) if (!mem_ce_n[k]) idx = k;
        if (rst_n) begin
            if (idx >= 0) ce_age = ce_age + 1; else ce_age = 0;
            if (!mem_oe_n) oe_age = oe_age + 1; else oe_age = 0;
            if (!mem_oe_n && idx < 0) check(0, "R3 oe without ce", 0, 1);
            if (ce_age == 1) begin
                check(idx == cur_dev, "R1 device select", idx, cur_dev);
                check(mem_addr == cur_low, "R1 address", mem_addr, cur_low);
                if (seen_sel) check(high_run >= FL, "R7 float gap", high_run, FL);
                seen_sel = 1;
            end else if (ce_age > 1) begin
                check(mem_addr == cur_low && idx == cur_dev, "R4 select held", mem_addr, cur_low);
            end
            if (oe_age == 1) check(ce_age == S + 1, "R3 oe lead", ce_age, S + 1);
            if (idx < 0) high_run = high_run + 1; else high_run = 0;
            if (idx >= 0 && ce_age >= ACC && oe_age >= OEC) mem_dq = mem_val(idx, mem_addr);
            else mem_dq = 8'hEE;
        end
    end

    // Monitor / scoreboard
    bit prev_valid = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            check(!prev_valid, "R6 single pulse", 1, 0);
            if (exp_q.size() == 0) begin
                check(0, "R7 unexpected result", rd_data, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data == e.data, "R5 data", rd_data, e.data);
                check(cyc == e.when, "R8 latency", cyc, e.when);
            end
        end
        prev_valid = rst_n && rd_valid;
    end

    // Driver: presents a request, leaves req_valid high on return
    task automatic issue(input int dev, input logic [15:0] low, output int acc_cyc);
        exp_t e;
        req_valid = 1'b1;
        req_addr = {2'(dev), low};
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc;
        cur_dev = dev;
        cur_low = low;
        e.data = mem_val(dev, low);
        e.when = cyc + T + 1;
        exp_q.push_back(e);
        @(negedge clk);
        check(!req_ready, "R7 ready low when busy", req_ready, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a0, a1, fc;
        repeat (3) @(negedge clk);
        check(&mem_ce_n, "R2 reset ce", mem_ce_n, 4'hF);
        check(mem_oe_n, "R2 reset oe", mem_oe_n, 1);
        check(req_ready, "R2 reset ready", req_ready, 1);
        check(!rd_valid, "R2 reset valid", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(0, 16'h0000, a0);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        issue(3, 16'hFFFF, a0);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);

        // Held requests: the next one waits through the float interval
        issue(1, 16'h1234, a0);
        issue(2, 16'hA5C3, a1);
        check(a1 - a0 == T + FL + 1, "R8 spacing", a1 - a0, T + FL + 1);
        a0 = a1;
        issue(3, 16'h00FF, a1);
        check(a1 - a0 == T + FL + 1, "R8 spacing", a1 - a0, T + FL + 1);
        for (int d = 0; d < N_DEV; d++) issue(d, 16'h8000 + 16'(d * 257), a0);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5 all returned", exp_q.size(), 0);

        // Variant without lead: ce and oe together, T = 3
        f_valid = 1'b1;
        f_addr = {1'b1, 16'h0042};
        while (!f_ready) @(negedge clk);
        fc = cyc;
        @(negedge clk);
        check(f_ce_n == 2'b01, "R9 ce select", f_ce_n, 2'b01);
        check(!f_oe_n, "R9 oe with ce", f_oe_n, 0);
        f_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(cyc == fc + 4, "R9 timing", cyc, fc + 4);
        check(f_rd_valid, "R9 valid at T+1", f_rd_valid, 1);
        check(f_rd_data == (8'h42 ^ 8'h5A), "R9 data", f_rd_data, 8'h42 ^ 8'h5A);
        @(negedge clk);
        check(!f_rd_valid, "R6 fast single pulse", f_rd_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule